// File: doc/BRIEF.md
# Host Bus Wait-State Handshake Controller

This block connects an asynchronous host processor strobe interface to an internal register/RAM access engine. Each host strobe produces exactly one internal read or write. The block reports progress to the host through an active-low ready line. It also drives an active-low I/O-enable that gates external address and data tri-state buffers. The internal engine is reached through a request/acknowledge port. The engine can take any number of cycles to answer.

A static strap picks one of two host protocols. In the zero-wait (buffered) protocol, ready idles high and means the block is free. It drops while an internal transfer runs. The host does not wait: address, direction and write data are captured when the strobe falls. A read hands back the data of the previous completed read. In the nonzero-wait (transparent) protocol, ready is a completion strobe. The host holds its strobe low until ready drops, and ready is released once the host lets go of the strobe. In this protocol only, an access can also target external RAM. The block then makes no internal request and only runs the buffer enable for a fixed number of wait cycles.

Every host input passes through a two-stage synchroniser before the sequencer uses it. All edge counts below are rising clock edges counted from the host's change of the strobe.

Top module: `host_wait_ctrl`

## Requirements
- R1: `mode_strap` low selects the zero-wait protocol and high selects the nonzero-wait protocol. Every host input is synchronised, so an accepted access raises `int_req` on the third rising edge after `host_strb_n` falls, and not before.
- R2: Nonzero-wait protocol: let the engine raise `int_ack` in the L-th cycle after `int_req` rises (L = 0 means the first cycle). Then `host_rdy_n` falls on edge L+4 after the strobe falls. On a read, `host_rdata` then carries the returned word. On a write, the engine has received the host's address and data.
- R3: Nonzero-wait protocol: `host_rdy_n` never falls while the synchronised strobe is high. If the host releases the strobe before the engine answers, the internal access still completes, but `host_rdy_n` stays high.
- R4: Nonzero-wait protocol: after the host releases the strobe, `host_rdy_n` returns high on the third rising edge.
- R5: Zero-wait protocol: `host_rdy_n` idles high. It falls on the same edge that raises `int_req` and rises on the edge that samples `int_ack`, so it stays low for L+1 cycles.
- R6: Zero-wait protocol: address, direction and write data are taken from the bus at the synchronised strobe fall. Changing the bus after the strobe is released does not alter the internal access.
- R7: `host_rdata` holds the word returned by the most recent completed internal read. Writes leave it unchanged. A zero-wait read therefore presents the previous read's data while its own transfer runs.
- R8: Zero-wait protocol: a strobe that falls while the block is busy is held in a one-entry slot. Ready returns high for exactly one cycle, and on the next edge the held access starts.
- R9: `host_io_en_n` falls on the edge where an access starts and stays low at least as long as `host_rdy_n` is low. It returns high on the same edge as `host_rdy_n` (nonzero-wait) or when the transfer ends (zero-wait).
- R10: Nonzero-wait protocol with `host_ext` high: no internal request is made, `host_io_en_n` goes low, and `host_rdy_n` falls on edge EXT_WAIT+3 after the strobe falls. In the zero-wait protocol, `host_ext` is ignored and the access goes to the engine.
- R11: After reset, `host_rdy_n` and `host_io_en_n` are high, `int_req` is low and `host_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_strap | input | 1 | Static protocol select: 0 zero-wait, 1 nonzero-wait |
| host_strb_n | input | 1 | Host transfer strobe, active low, asynchronous |
| host_wr | input | 1 | Host direction: 1 write, 0 read |
| host_ext | input | 1 | Access targets external RAM (nonzero-wait only) |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Data of the latest completed internal read |
| host_rdy_n | output | 1 | Ready handshake, active low |
| host_io_en_n | output | 1 | External buffer enable, active low |
| int_req | output | 1 | Internal access request, held until acknowledged |
| int_wr | output | 1 | Internal access direction |
| int_addr | output | ADDR_W | Internal access address |
| int_wdata | output | DATA_W | Internal write data |
| int_ack | input | 1 | Internal access done, one cycle |
| int_rdata | input | DATA_W | Internal read data, valid with int_ack |

## Verification
The bench builds the block with ADDR_W = 4, DATA_W = 16 and EXT_WAIT = 2. With a 16-word address space, every location can be read, written and read back in both protocols. The bench's engine model sweeps the answer latency from 0 to 3. This turns every expected ready edge into a small sum that the bench computes. A longer latency of 5 or 6 makes room for the early-release case and for a second strobe landing mid-transfer. The short external wait keeps the external path's edge count distinct from the internal one.

// File: rtl/hwc_pkg.sv
// Package: shared types and constants for the host wait-state controller.
// Assumes: nothing beyond IEEE 1800-2017.
package hwc_pkg;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a host strobe
        ST_XFER = 2'd1,   // internal request outstanding
        ST_EXTW = 2'd2,   // external RAM wait window
        ST_DONE = 2'd3    // completion shown, waiting for strobe release
    } seq_state_t;

    // Strap encodings.
    localparam logic MODE_ZERO_WAIT = 1'b0;
    localparam logic MODE_WAITED    = 1'b1;

    // Counter width that can hold values 0..n (at least one bit).
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/hwc_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes: the bundle is quasi-static around the sampling edge (the host
// holds the bus steady while the strobe is synchronised); STAGES >= 1.
module hwc_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hwc_hold.sv
// Module: one-entry hold slot for a host request that arrives while busy.
// Assumes: a load while the slot is full and not being taken is dropped
// (the host is expected to wait for ready before a third strobe).
module hwc_hold #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [RW-1:0] load_data,
    input  logic          take,
    output logic          valid,
    output logic [RW-1:0] data
);

    // Fill on load, drain on take; a simultaneous load refills the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (take) begin
            valid <= load;
            if (load) data <= load_data;
        end else if (load && !valid) begin
            valid <= 1'b1;
            data  <= load_data;
        end
    end

    // The sequencer only drains an occupied slot.
    p_take_needs_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> valid);

endmodule

// File: rtl/hwc_seq.sv
// Module: access sequencer. Starts one internal or external access per
// synchronised strobe fall and drives the ready and buffer-enable outputs
// according to the selected protocol.
// Assumes: strb_low, mode_wait and req_bus are already synchronised;
// the engine holds int_ack for one cycle; EXT_WAIT >= 1.
module hwc_seq
    import hwc_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 16,
    parameter int EXT_WAIT = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_wait,
    input  logic                          strb_low,
    input  logic [2+ADDR_W+DATA_W-1:0]    req_bus,
    input  logic                          hold_valid,
    input  logic [2+ADDR_W+DATA_W-1:0]    hold_q,
    output logic                          hold_load,
    output logic                          hold_take,
    output logic                          int_req,
    output logic                          int_wr,
    output logic [ADDR_W-1:0]             int_addr,
    output logic [DATA_W-1:0]             int_wdata,
    input  logic                          int_ack,
    input  logic [DATA_W-1:0]             int_rdata,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          rdy_n,
    output logic                          io_en_n
);

    localparam int RW = 2 + ADDR_W + DATA_W;
    localparam int CW = cnt_width(EXT_WAIT);
    localparam logic [CW-1:0] EXT_LAST = CW'(EXT_WAIT - 1);

    seq_state_t        state;
    logic              strb_prev;
    logic              strb_fall;
    logic              use_hold;
    logic              start;
    logic [RW-1:0]     start_req;
    logic              s_wr;
    logic              s_ext;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_data;
    logic              ext_path;
    logic [CW-1:0]     ext_cnt;

    // Remember the previous synchronised strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strb_prev <= 1'b0;
        else        strb_prev <= strb_low;
    end

    // Decide whether and from where a new access starts this cycle.
    always_comb begin
        strb_fall = strb_low && !strb_prev;
        use_hold  = (mode_wait == MODE_ZERO_WAIT) && hold_valid;
        start     = (state == ST_IDLE) && (use_hold || strb_fall);
        start_req = use_hold ? hold_q : req_bus;
        s_wr      = start_req[RW-1];
        s_ext     = start_req[RW-2];
        s_addr    = start_req[DATA_W +: ADDR_W];
        s_data    = start_req[DATA_W-1:0];
        ext_path  = (mode_wait == MODE_WAITED) && s_ext;
        hold_take = (state == ST_IDLE) && use_hold;
        hold_load = (mode_wait == MODE_ZERO_WAIT) && strb_fall &&
                    ((state != ST_IDLE) || hold_valid);
    end

    // Main state machine with registered handshake outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            int_req   <= 1'b0;
            int_wr    <= 1'b0;
            int_addr  <= '0;
            int_wdata <= '0;
            rd_data   <= '0;
            rdy_n     <= 1'b1;
            io_en_n   <= 1'b1;
            ext_cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        io_en_n <= 1'b0;
                        if (ext_path) begin
                            state   <= ST_EXTW;
                            ext_cnt <= '0;
                        end else begin
                            state     <= ST_XFER;
                            int_req   <= 1'b1;
                            int_wr    <= s_wr;
                            int_addr  <= s_addr;
                            int_wdata <= s_data;
                            if (mode_wait == MODE_ZERO_WAIT) rdy_n <= 1'b0;
                        end
                    end
                end
                ST_XFER: begin
                    if (int_ack) begin
                        int_req <= 1'b0;
                        if (!int_wr) rd_data <= int_rdata;
                        if (mode_wait == MODE_WAITED && strb_low) begin
                            state <= ST_DONE;
                            rdy_n <= 1'b0;
                        end else begin
                            state   <= ST_IDLE;
                            rdy_n   <= 1'b1;
                            io_en_n <= 1'b1;
                        end
                    end
                end
                ST_EXTW: begin
                    ext_cnt <= ext_cnt + 1'b1;
                    if (ext_cnt == EXT_LAST) begin
                        if (strb_low) begin
                            state <= ST_DONE;
                            rdy_n <= 1'b0;
                        end else begin
                            state   <= ST_IDLE;
                            io_en_n <= 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    if (!strb_low) begin
                        state   <= ST_IDLE;
                        rdy_n   <= 1'b1;
                        io_en_n <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: completion is only shown while the host still holds the strobe.
    p_rdy_fall_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wait == MODE_WAITED) && $fell(rdy_n) |-> strb_low);

    // R4: once the strobe is seen released, ready returns high next edge.
    p_rdy_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wait == MODE_WAITED) && !rdy_n && !strb_low |=> rdy_n);

    // R2: a request and its operands hold steady until acknowledged.
    p_req_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_req && !int_ack |=> int_req && $stable(int_addr) &&
                                $stable(int_wdata) && $stable(int_wr));

    // R5: in zero-wait mode the busy indication accompanies a new request.
    p_zero_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wait == MODE_ZERO_WAIT) && $rose(int_req) |-> !rdy_n);

    // R5: in zero-wait mode ready only comes back after an acknowledge.
    p_zero_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wait == MODE_ZERO_WAIT) && $rose(rdy_n) |-> $past(int_ack));

    // R9: the buffer enable covers every cycle in which ready is low.
    p_ioen_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |-> !io_en_n);

    // R10: the external wait window never touches the internal port.
    p_ext_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXTW) |-> !int_req);

endmodule

// File: rtl/host_wait_ctrl.sv
// Module: top of the host wait-state handshake controller. Synchronises
// the host inputs, keeps a one-entry hold slot for zero-wait back-to-back
// strobes, and runs the access sequencer.
// Assumes: mode_strap is static after reset; the host keeps address, data
// and direction stable from the strobe fall for at least three clocks.
module host_wait_ctrl
    import hwc_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 16,
    parameter int EXT_WAIT    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_strap,
    input  logic              host_strb_n,
    input  logic              host_wr,
    input  logic              host_ext,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rdy_n,
    output logic              host_io_en_n,
    output logic              int_req,
    output logic              int_wr,
    output logic [ADDR_W-1:0] int_addr,
    output logic [DATA_W-1:0] int_wdata,
    input  logic              int_ack,
    input  logic [DATA_W-1:0] int_rdata
);

    localparam int RW = 2 + ADDR_W + DATA_W;
    localparam int CTL_W = 4;

    logic [CTL_W-1:0] ctl_s;
    logic [RW-3:0]    bus_s;
    logic             mode_s;
    logic             strb_low;
    logic [RW-1:0]    req_bus;
    logic             hold_load;
    logic             hold_take;
    logic             hold_valid;
    logic [RW-1:0]    hold_q;

    // Control lines: strap, strobe (idles high), direction, external flag.
    hwc_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0100)
    ) u_sync_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({mode_strap, host_strb_n, host_wr, host_ext}),
        .q     (ctl_s)
    );

    // Address and write data.
    hwc_sync #(
        .W       (RW - 2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_sync_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_addr, host_wdata}),
        .q     (bus_s)
    );

    assign mode_s   = ctl_s[3];
    assign strb_low = !ctl_s[2];
    assign req_bus  = {ctl_s[1], ctl_s[0], bus_s};

    hwc_hold #(
        .RW (RW)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (hold_load),
        .load_data (req_bus),
        .take      (hold_take),
        .valid     (hold_valid),
        .data      (hold_q)
    );

    hwc_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .EXT_WAIT (EXT_WAIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wait  (mode_s),
        .strb_low   (strb_low),
        .req_bus    (req_bus),
        .hold_valid (hold_valid),
        .hold_q     (hold_q),
        .hold_load  (hold_load),
        .hold_take  (hold_take),
        .int_req    (int_req),
        .int_wr     (int_wr),
        .int_addr   (int_addr),
        .int_wdata  (int_wdata),
        .int_ack    (int_ack),
        .int_rdata  (int_rdata),
        .rd_data    (host_rdata),
        .rdy_n      (host_rdy_n),
        .io_en_n    (host_io_en_n)
    );

    // R11: the handshake lines leave reset deasserted.
    p_reset_idle_r11: assert property (@(posedge clk)
        !rst_n |=> host_rdy_n && host_io_en_n && !int_req);

endmodule

// File: tb/sim_host_wait_ctrl.sv
module sim_host_wait_ctrl;

    localparam int AW = 4;
    localparam int DW = 16;
    localparam int EW = 2;
    localparam int NWORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_strap = 1'b1;
    logic          host_strb_n = 1'b1;
    logic          host_wr = 1'b0;
    logic          host_ext = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_rdy_n;
    logic          host_io_en_n;
    logic          int_req;
    logic          int_wr;
    logic [AW-1:0] int_addr;
    logic [DW-1:0] int_wdata;
    logic          int_ack = 1'b0;
    logic [DW-1:0] int_rdata = '0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int lat = 0;
    int eng_cnt = 0;
    int req_rises = 0;
    logic req_prev = 1'b0;
    logic [DW-1:0] mem [NWORDS];
    logic [DW-1:0] ref_mem [NWORDS];
    logic [DW-1:0] last_rd = '0;

    always #10 clk = ~clk;

    host_wait_ctrl #(.ADDR_W(AW), .DATA_W(DW), .EXT_WAIT(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap),
        .host_strb_n(host_strb_n), .host_wr(host_wr), .host_ext(host_ext),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rdy_n(host_rdy_n),
        .host_io_en_n(host_io_en_n), .int_req(int_req), .int_wr(int_wr),
        .int_addr(int_addr), .int_wdata(int_wdata), .int_ack(int_ack),
        .int_rdata(int_rdata)
    );

    function automatic logic [DW-1:0] init_word(input int i);
        return 16'hA5A5 ^ DW'(i * 16'h0123);
    endfunction

    // Engine model: answers after lat cycles, stores and returns words.
    always @(negedge clk) begin
        if (!rst_n) begin
            int_ack <= 1'b0;
            eng_cnt <= 0;
            for (int i = 0; i < NWORDS; i++) mem[i] <= init_word(i);
        end else if (int_req && !int_ack) begin
            if (eng_cnt == lat) begin
                int_ack <= 1'b1;
                eng_cnt <= 0;
                if (int_wr) mem[int_addr] <= int_wdata;
                else        int_rdata <= mem[int_addr];
            end else begin
                eng_cnt <= eng_cnt + 1;
            end
        end else begin
            int_ack <= 1'b0;
        end
        if (int_req && !req_prev) req_rises <= req_rises + 1;
        req_prev <= int_req;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0;
        mode_strap = strap;
        host_strb_n = 1'b1;
        tick(); tick(); tick();
        rst_n = 1'b1;
        for (int i = 0; i < NWORDS; i++) ref_mem[i] = init_word(i);
        last_rd = '0;
        check(host_rdy_n === 1'b1, "R11 rdy", host_rdy_n, 1);
        check(host_io_en_n === 1'b1, "R11 io_en", host_io_en_n, 1);
        check(int_req === 1'b0, "R11 req", int_req, 0);
        check(host_rdata === '0, "R11 rdata", host_rdata, 0);
        tick(); tick(); tick(); tick();
    endtask

    // Nonzero-wait access; exp_edges is the expected edge of the ready fall.
    task automatic nz_acc(input logic wr, input logic ext, input int a,
                          input logic [DW-1:0] d, input int l, input int exp_edges);
        int n;
        int m;
        int rises0;
        lat = l;
        rises0 = req_rises;
        host_wr = wr; host_ext = ext; host_addr = AW'(a); host_wdata = d;
        host_strb_n = 1'b0;
        n = 0;
        do begin tick(); n++; end while (host_rdy_n && n < 40);
        check(n == exp_edges, ext ? "R10 ext ready edge" : "R2 ready edge", n, exp_edges);
        check(host_io_en_n === 1'b0, "R9 io_en low with ready", host_io_en_n, 0);
        if (!wr && !ext) begin
            check(host_rdata === ref_mem[a], "R2 read data", host_rdata, ref_mem[a]);
            last_rd = ref_mem[a];
        end
        host_strb_n = 1'b1;
        m = 0;
        do begin tick(); m++; end while (!host_rdy_n && m < 10);
        check(m == 3, "R4 ready release edge", m, 3);
        check(host_io_en_n === 1'b1, "R9 io_en released", host_io_en_n, 1);
        if (ext) begin
            check(req_rises == rises0, "R10 no internal request", req_rises - rises0, 0);
        end else if (wr) begin
            ref_mem[a] = d;
            check(mem[a] === d, "R2 write stored", mem[a], d);
        end
        check(host_rdata === last_rd, "R7 rdata holds last read", host_rdata, last_rd);
        tick();
    endtask

    // Zero-wait access; bus is scrambled right after the strobe release.
    task automatic zw_acc(input logic wr, input logic ext, input int a,
                          input logic [DW-1:0] d, input int l);
        int m;
        int rises0;
        lat = l;
        rises0 = req_rises;
        host_wr = wr; host_ext = ext; host_addr = AW'(a); host_wdata = d;
        host_strb_n = 1'b0;
        tick(); tick();
        check(int_req === 1'b0 && host_rdy_n === 1'b1, "R1 no start before edge 3",
              {int_req, host_rdy_n}, 2'b01);
        tick();
        check(int_req === 1'b1, "R1 request on edge 3", int_req, 1);
        check(host_rdy_n === 1'b0, "R5 busy with request", host_rdy_n, 0);
        check(host_io_en_n === 1'b0, "R9 io_en busy", host_io_en_n, 0);
        check(host_rdata === last_rd, "R7 prior read data", host_rdata, last_rd);
        host_strb_n = 1'b1;
        host_wr = ~wr; host_addr = ~AW'(a); host_wdata = ~d;
        m = 0;
        do begin tick(); m++; end while (!host_rdy_n && m < 20);
        check(m == l + 1, "R5 busy length", m, l + 1);
        check(host_io_en_n === 1'b1, "R9 io_en idle", host_io_en_n, 1);
        if (ext) check(req_rises == rises0 + 1, "R10 ext ignored in zero-wait",
                       req_rises - rises0, 1);
        if (wr) begin
            ref_mem[a] = d;
            check(mem[a] === d, "R6 captured write", mem[a], d);
        end else begin
            last_rd = ref_mem[a];
        end
        check(host_rdata === last_rd, "R7 rdata after access", host_rdata, last_rd);
        tick();
    endtask

    initial begin
        logic [DW-1:0] d;
        int n;
        bit saw_low;

        // Nonzero-wait protocol.
        do_reset(1'b1);
        for (int l = 0; l < 4; l++) begin
            for (int a = 0; a < NWORDS; a++) begin
                d = DW'(16'h5A00 ^ (l * 16'h1000) ^ (a * 16'h0111));
                nz_acc(1'b0, 1'b0, a, '0, l, l + 4);
                nz_acc(1'b1, 1'b0, a, d, l, l + 4);
                nz_acc(1'b0, 1'b0, a, '0, l, l + 4);
            end
        end
        for (int a = 0; a < 4; a++) begin
            nz_acc(1'b1, 1'b1, a, 16'hDEAD, 1, EW + 3);
            nz_acc(1'b0, 1'b1, a, '0, 1, EW + 3);
            check(mem[a] === ref_mem[a], "R10 ext leaves memory", mem[a], ref_mem[a]);
        end

        // R3: strobe released before the engine answers.
        lat = 5;
        host_wr = 1'b1; host_ext = 1'b0; host_addr = 4'd7; host_wdata = 16'h7E57;
        host_strb_n = 1'b0;
        tick(); tick(); tick(); tick();
        host_strb_n = 1'b1;
        saw_low = 1'b0;
        for (int i = 0; i < 14; i++) begin
            tick();
            if (!host_rdy_n) saw_low = 1'b1;
        end
        check(!saw_low, "R3 no ready after early release", saw_low, 0);
        check(mem[7] === 16'h7E57, "R3 access still completes", mem[7], 16'h7E57);
        check(host_io_en_n === 1'b1, "R3 io_en released", host_io_en_n, 1);
        ref_mem[7] = 16'h7E57;
        nz_acc(1'b0, 1'b0, 7, '0, 0, 4);

        // Zero-wait protocol.
        do_reset(1'b0);
        for (int l = 0; l < 4; l++) begin
            for (int a = 0; a < NWORDS; a++) begin
                d = DW'(16'hC300 ^ (l * 16'h0F00) ^ (a * 16'h0013));
                zw_acc(1'b0, 1'b0, a, '0, l);
                zw_acc(1'b1, 1'b0, a, d, l);
                zw_acc(1'b0, 1'b0, a, '0, l);
            end
        end
        zw_acc(1'b1, 1'b1, 3, 16'hBEEF, 2);
        zw_acc(1'b0, 1'b1, 3, '0, 1);

        // R8: second strobe lands while the first transfer is running.
        lat = 6;
        host_wr = 1'b1; host_ext = 1'b0; host_addr = 4'd1; host_wdata = 16'h1111;
        host_strb_n = 1'b0;
        tick(); tick(); tick();
        host_strb_n = 1'b1;
        tick(); tick();
        host_addr = 4'd2; host_wdata = 16'h2222;
        host_strb_n = 1'b0;
        tick(); tick(); tick();
        host_strb_n = 1'b1;
        host_addr = 4'd9; host_wdata = 16'h9999;
        check(host_rdy_n === 1'b0, "R8 still busy with first", host_rdy_n, 0);
        n = 0;
        do begin tick(); n++; end while (!host_rdy_n && n < 20);
        check(host_rdy_n === 1'b1, "R8 ready back", host_rdy_n, 1);
        tick();
        check(host_rdy_n === 1'b0 && int_req === 1'b1, "R8 held access starts next edge",
              {host_rdy_n, int_req}, 2'b01);
        n = 0;
        do begin tick(); n++; end while (!host_rdy_n && n < 20);
        check(n == 7, "R8 held access busy length", n, 7);
        check(mem[1] === 16'h1111, "R8 first write", mem[1], 16'h1111);
        check(mem[2] === 16'h2222, "R8 held write", mem[2], 16'h2222);
        check(mem[9] === ref_mem[9], "R6 late bus ignored", mem[9], ref_mem[9]);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule